// File: doc/BRIEF.md
# Third-order sinc decimator for a 1-bit delta-sigma stream

This block turns the single-bit output of a delta-sigma modulator into signed multi-bit samples at a reduced rate. The filter is three running-sum stages followed by three first-difference stages. The running sums advance once for each accepted modulator bit. The difference stages advance once every R accepted bits, where R is the decimation ratio supplied on an input port. The arithmetic matches the ideal transfer function exactly. The bit accepted in a cycle is already part of the running sums in that same cycle, and the difference outputs are formed without registers in their path. A result therefore depends only on the last 3R−2 accepted bits. A full-accuracy value is available on the third decimation point after a clear.

A host normally pulses the clear input a short time before the wanted measurement instant and then keeps the bit enable running. It takes the third valid result after the clear. The decimation enable can drop individual results without disturbing the filter state. The wide internal result is arithmetically shifted right by a build-time amount and then clamped to a 16-bit signed output.

Top module: `sinc3_decimator`

## Requirements
- R1: Input bit 1 is weighted +1 and bit 0 is weighted −1. With ratio R, three or more decimation points of constant 1 input give a wide result of +R³, and constant 0 input gives −R³.
- R2: A bit accepted (bitEn high) in the same cycle as a decimation point is included in that point's result. The result equals the sum over j of c[j]·x[n−j], where c is the threefold self-convolution of a length-R boxcar and x[n] is the bit accepted at that point.
- R3: After a clear, the first and second results use zero for all history before the clear. From the third decimation point on, results equal the steady-state sum of R2.
- R4: A decimation point occurs on every R-th accepted bit counted from the last clear. outVld rises in the following cycle and lasts exactly one cycle.
- R5: In a cycle with bitEn low, no filter state and no sample count changes, and bitIn is ignored.
- R6: When decEn is low at a decimation point, outVld stays low and outData holds its previous value. The filter state still advances, so later results are unchanged.
- R7: A clear takes one clock. It zeroes all running sums, difference delays, the sample count, outData and outVld, and it overrides a bitEn in the same cycle (that bit is discarded).
- R8: A ratio value of 0 or 1 behaves as a ratio of 2. The ratio is only changed while clear is high.
- R9: outData is the wide result arithmetically shifted right by OUT_SHIFT, then clamped to [−32768, 32767].
- R10: Running sums wrap modulo 2^(1+3·RATIO_W). Results stay exact over arbitrarily long runs at any ratio up to 2^RATIO_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all filter state |
| bitEn | input | 1 | Accept bitIn in this cycle (modulator-rate enable) |
| decEn | input | 1 | Publish the result at a decimation point |
| bitIn | input | 1 | Modulator bit |
| ratio | input | RATIO_W | Decimation ratio R |
| outData | output | OUT_W | Signed scaled and clamped result |
| outVld | output | 1 | One-cycle strobe for a new result |

## Verification
Several properties are checked on every cycle. The sample count and running sums stay frozen without bitEn. A clear empties the count and the output register one cycle later. The output holds whenever no result is published. outVld never lasts two cycles. Other behaviours can only be shown by the bench scenarios, which compare against an independent convolution model. These are the exact values after settling, the inclusion of the bit accepted in the same cycle as a decimation point, the partial results before the third point, the clamping, the ratio-below-two rule and exactness after the running sums have wrapped many times.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int NSTAGE = 3;

  typedef struct packed {
    logic intStep;  // accept one bit into the running sums
    logic decStep;  // decimation point: advance the difference stages
    logic emit;     // publish the result of this decimation point
    logic clrAll;   // synchronous clear of all state
  } sinc3Strobe_t;
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               bitEn,
  input  logic               decEn,
  input  logic [RATIO_W-1:0] ratio,
  output sinc3Strobe_t       stb
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] lastIdx;
  logic               atWrap;

  // ratios below two are treated as two
  assign lastIdx = (ratio < RATIO_W'(2)) ? RATIO_W'(1) : ratio - RATIO_W'(1);
  assign atWrap  = (cnt >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (bitEn) begin
      cnt <= atWrap ? '0 : cnt + RATIO_W'(1);
    end
  end

  always_comb begin
    stb.clrAll  = clr;
    stb.intStep = bitEn && !clr;
    stb.decStep = bitEn && !clr && atWrap;
    stb.emit    = bitEn && !clr && atWrap && decEn;
  end

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !clr) |=> $stable(cnt));

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0));
endmodule

// File: rtl/sinc3_datapath.sv
module sinc3_datapath
  import sinc3_pkg::*;
#(
  parameter int W         = 25,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitIn,
  input  sinc3Strobe_t            stb,
  output logic signed [OUT_W-1:0] outData,
  output logic                    outVld
);
  localparam logic signed [W-1:0] SAT_HI = W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [W-1:0] SAT_LO = ~SAT_HI;

  logic signed [W-1:0] sample;
  logic signed [W-1:0] intReg  [NSTAGE];
  logic signed [W-1:0] intNow  [NSTAGE];
  logic signed [W-1:0] dlyReg  [NSTAGE];
  logic signed [W-1:0] diffNow [NSTAGE];
  logic signed [W-1:0] scaled;
  logic signed [W-1:0] clipped;

  assign sample = bitIn ? W'(1) : {W{1'b1}};

  // running sums: current bit reaches the last stage in the same cycle
  always_comb begin
    intNow[0] = intReg[0] + sample;
    for (int k = 1; k < NSTAGE; k++) intNow[k] = intReg[k] + intNow[k-1];
  end

  // differences: combinational outputs, only the delays are registered
  always_comb begin
    diffNow[0] = intNow[NSTAGE-1] - dlyReg[0];
    for (int k = 1; k < NSTAGE; k++) diffNow[k] = diffNow[k-1] - dlyReg[k];
  end

  generate
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          intReg[s] <= '0;
        end else if (stb.clrAll) begin
          intReg[s] <= '0;
        end else if (stb.intStep) begin
          intReg[s] <= intNow[s];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dlyReg[s] <= '0;
        end else if (stb.clrAll) begin
          dlyReg[s] <= '0;
        end else if (stb.decStep) begin
          if (s == 0) dlyReg[s] <= intNow[NSTAGE-1];
          else        dlyReg[s] <= diffNow[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign scaled  = diffNow[NSTAGE-1] >>> OUT_SHIFT;
  assign clipped = (scaled > SAT_HI) ? SAT_HI : ((scaled < SAT_LO) ? SAT_LO : scaled);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      outVld  <= 1'b0;
    end else if (stb.clrAll) begin
      outData <= '0;
      outVld  <= 1'b0;
    end else begin
      outVld <= stb.emit;
      if (stb.emit) outData <= OUT_W'(clipped);
    end
  end

  assert_int_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.intStep && !stb.clrAll) |=> ($stable(intReg[0]) && $stable(intReg[1]) && $stable(intReg[2])));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.emit && !stb.clrAll) |=> ($stable(outData) && !outVld));

  assert_out_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (!outVld && outData == '0));
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int RATIO_W   = 8,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clr,
  input  logic                    bitEn,
  input  logic                    decEn,
  input  logic                    bitIn,
  input  logic [RATIO_W-1:0]      ratio,
  output logic signed [OUT_W-1:0] outData,
  output logic                    outVld
);
  localparam int W = 1 + NSTAGE * RATIO_W;

  sinc3Strobe_t stb;

  sinc3_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clr(clr), .bitEn(bitEn), .decEn(decEn),
    .ratio(ratio), .stb(stb)
  );

  sinc3_datapath #(.W(W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .stb(stb),
    .outData(outData), .outVld(outVld)
  );

  assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    outVld |=> !outVld);
endmodule

// File: tb/sim_sinc3_decimator.sv
module sim_sinc3_decimator;
  localparam int RW = 8;
  localparam int SH = 0;
  localparam int MAXH = 3 * 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clr = 1'b0, bitEn = 1'b0, decEn = 1'b0, bitIn = 1'b0;
  logic [RW-1:0] ratio = RW'(4);
  logic signed [15:0] outData;
  logic outVld;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R7";

  longint hist [MAXH];
  longint coef [MAXH];
  longint b2   [MAXH];
  int effR = 4, mCnt = 0;
  longint expData = 0;
  logic expVld = 1'b0;

  always #2.5 clk = ~clk;

  sinc3_decimator #(.RATIO_W(RW), .OUT_W(16), .OUT_SHIFT(SH)) u0 (
    .clk(clk), .rstN(rstN), .clr(clr), .bitEn(bitEn), .decEn(decEn),
    .bitIn(bitIn), .ratio(ratio), .outData(outData), .outVld(outVld)
  );

  function automatic void buildCoef(int r);
    for (int j = 0; j < MAXH; j++) begin coef[j] = 0; b2[j] = 0; end
    for (int j = 0; j < 2*r-1; j++) b2[j] = (j + 1 < 2*r - 1 - j) ? j + 1 : 2*r - 1 - j;
    for (int j = 0; j < 3*r-2; j++)
      for (int a = 0; a < r; a++)
        if (j - a >= 0 && j - a < 2*r-1) coef[j] += b2[j-a];
  endfunction

  function automatic longint satScale(longint y);
    longint v = y >>> SH;
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic void modelClock(logic b, logic m, logic d, logic c);
    if (c) begin
      for (int j = 0; j < MAXH; j++) hist[j] = 0;
      mCnt = 0; expVld = 1'b0; expData = 0;
      return;
    end
    expVld = 1'b0;
    if (m) begin
      for (int j = MAXH-1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = b ? 1 : -1;
      mCnt++;
      if (mCnt == effR) begin
        longint y = 0;
        mCnt = 0;
        for (int j = 0; j < 3*effR-2; j++) y += coef[j] * hist[j];
        if (d) begin expVld = 1'b1; expData = satScale(y); end
      end
    end
  endfunction

  task automatic compareNow();
    checks++;
    if (outVld !== expVld || longint'(outData) != expData) begin
      errors++;
      $display("FAIL %s: outVld=%0b outData=%0d expected outVld=%0b outData=%0d",
               curReq, outVld, outData, expVld, expData);
    end
  endtask

  task automatic step(logic b, logic m, logic d, logic c);
    bitIn = b; bitEn = m; decEn = d; clr = c;
    @(posedge clk);
    modelClock(b, m, d, c);
    @(negedge clk);
    compareNow();
  endtask

  task automatic restart(int r);
    ratio = RW'(r);
    effR = (r < 2) ? 2 : r;
    buildCoef(effR);
    step(1'b0, 1'b1, 1'b1, 1'b1);  // clear wins over bitEn (R7)
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL R4 watchdog: cycles %0d expected below %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    buildCoef(4);
    for (int j = 0; j < MAXH; j++) hist[j] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R7"; compareNow();   // reset state

    // R1 / R3 / R4: constant ones then constant zeros, ratio 4
    curReq = "R1"; restart(4);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    checks++;
    if (outData != 64) begin errors++; $display("FAIL R1: outData=%0d expected 64", outData); end
    curReq = "R3"; restart(4);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    checks++;
    if (outData != -64) begin errors++; $display("FAIL R3: outData=%0d expected -64", outData); end

    // R2: lone opposite bit landing exactly on decimation points
    curReq = "R2"; restart(5);
    for (int i = 0; i < 40; i++) step((i % 5) == 4, 1'b1, 1'b1, 1'b0);

    // R5: random bits with bitEn gaps, toggling bitIn while idle
    curReq = "R5"; restart(8);
    for (int i = 0; i < 400; i++) step($urandom_range(1, 0) == 1, ($urandom_range(3, 0) != 0), 1'b1, 1'b0);

    // R6: decEn dropped for some decimation points
    curReq = "R6"; restart(6);
    for (int i = 0; i < 300; i++) step($urandom_range(1, 0) == 1, 1'b1, (i / 20) % 2 == 0, 1'b0);

    // R8: ratio 1 and 0 behave as 2
    curReq = "R8"; restart(1);
    for (int i = 0; i < 40; i++) step($urandom_range(1, 0) == 1, 1'b1, 1'b1, 1'b0);
    restart(0);
    for (int i = 0; i < 40; i++) step(i % 3 == 0, 1'b1, 1'b1, 1'b0);

    // R9: clamping at ratio 125
    curReq = "R9"; restart(125);
    for (int i = 0; i < 500; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 500; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 750; i++) step(($urandom_range(99, 0) < 52), 1'b1, 1'b1, 1'b0);

    // R10: long run at ratio 255 with running sums wrapping repeatedly
    curReq = "R10"; restart(255);
    for (int i = 0; i < 6000; i++) step(($urandom_range(99, 0) < 50), 1'b1, 1'b1, 1'b0);

    // R7: clear in the middle of a run with bitEn high
    curReq = "R7";
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 1'b1, (i == 37));
    restart(3);
    for (int i = 0; i < 30; i++) step(i % 2 == 0, 1'b1, 1'b1, (i == 10));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule